// File: doc/BRIEF.md
# Segmented Indexed Integer Dot-Product Unit

This block is a SIMD multiply-accumulate datapath for vectors. Each destination lane adds, to its previous value, the sum of four products. The four products pair the lane's own four multiplicand elements with four elements taken from an indexed operand vector. The indexed operand is not read lane by lane. The vector is split into 128-bit segments, and in each segment a small index selects one group of four elements. That one group is then broadcast to every destination lane of the segment.

Two element sizes are supported:

- **Byte sources:** 8-bit elements feeding 32-bit lanes.
- **Halfword sources:** 16-bit elements feeding 64-bit lanes.

One control bit selects a signed or an unsigned reading of both source operands. An active-length input, counted in 64-bit chunks, marks how much of the vector the operation covers. Every destination chunk past that length is written as zero.

A single-cycle `start` pulse captures the result into an output register. A `done` pulse follows on the next cycle. The result is formed entirely from the input vectors before anything is written. Because of this, a caller that feeds the destination back as a source still gets the correct answer.

Top module: `idot_unit`

## Requirements
- R1: Byte mode (`elem_half`=0). For segment s and 32-bit lane i within it, the new lane value is the old lane value plus the sum over k=0..3 of N byte (4i+k) times M byte k of the selected group. The selected group is bits [s*128 + idx*32 +: 32] of `src_m`.
- R2: Halfword mode (`elem_half`=1). For segment s and 64-bit lane j within it, the new lane value is the old lane value plus the sum over k=0..3 of N halfword (4j+k) times M halfword k of the selected group. The selected group is bits [s*128 + idx[0]*64 +: 64] of `src_m`.
- R3: Each segment draws its group only from its own 128 bits of `src_m`. Every lane of that segment uses the same group.
- R4: In halfword mode `idx[1]` has no effect on the result.
- R5: `is_unsigned`=1 zero-extends both N and M elements. `is_unsigned`=0 sign-extends both.
- R6: Products are exact. Lane sums wrap modulo 2^32 in byte mode and 2^64 in halfword mode, with no saturation.
- R7: A 64-bit chunk c of the result is zero when c >= `act_len`. An `act_len` of 1 in byte mode is legal and keeps exactly the low two lanes. An `act_len` at or above VLEN/64 keeps the whole vector.
- R8: `done` is high exactly in the cycle after a cycle with `start` high, and the captured result is visible at that time. Without `start`, `result` holds its value.
- R9: While reset is asserted, `done` is 0 and `result` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture pulse; all other inputs must be stable while it is high |
| elem_half | input | 1 | 0 = byte sources into 32-bit lanes, 1 = halfword sources into 64-bit lanes |
| is_unsigned | input | 1 | 1 = unsigned sources, 0 = signed sources |
| idx | input | 2 | Group index within each segment (halfword mode uses bit 0 only) |
| act_len | input | LEN_W | Active length in 64-bit chunks |
| acc_in | input | VLEN | Old destination vector |
| src_n | input | VLEN | Multiplicand vector |
| src_m | input | VLEN | Indexed operand vector |
| done | output | 1 | One-cycle completion pulse |
| result | output | VLEN | Registered updated destination vector |

## Verification
The bound checker watches the handshake timing on every cycle. It also checks that `result` holds its value between captures, and that every chunk past the captured active length is zero.

The arithmetic can only be shown by the bench's scenarios, which compare against a reference computed in the bench. These include:

- the per-segment group broadcast;
- signed versus unsigned extension;
- modulo wrap at the lane width;
- halfword mode ignoring the upper index bit;
- the 64-bit byte-mode length and the clamped over-long length.

// File: rtl/idot_pkg.sv
package idot_pkg;
  localparam int SEG_W   = 128;
  localparam int CHUNK_W = 64;
  localparam int BYTE_EW = 8;
  localparam int HALF_EW = 16;
  localparam int BYTE_LW = 32;
  localparam int HALF_LW = 64;

  typedef enum logic {
    ELEM_BYTE = 1'b0,
    ELEM_HALF = 1'b1
  } elem_e;
endpackage

// File: rtl/idot_lane.sv
module idot_lane #(
  parameter int EW = 8,
  parameter int LW = 32
) (
  input  logic          uns,
  input  logic [4*EW-1:0] n_grp,
  input  logic [4*EW-1:0] m_grp,
  input  logic [LW-1:0] acc,
  output logic [LW-1:0] sum
);
  localparam int PW = 2*EW + 2;

  logic [LW-1:0] term [4];

  for (genvar k = 0; k < 4; k++) begin : g_prod
    logic signed [EW:0]   n_x;
    logic signed [EW:0]   m_x;
    logic signed [PW-1:0] prod;
    assign n_x  = {~uns & n_grp[k*EW+EW-1], n_grp[k*EW +: EW]};
    assign m_x  = {~uns & m_grp[k*EW+EW-1], m_grp[k*EW +: EW]};
    assign prod = PW'(n_x) * PW'(m_x);
    assign term[k] = {{(LW-PW){prod[PW-1]}}, prod};
  end

  assign sum = acc + term[0] + term[1] + term[2] + term[3];
endmodule

// File: rtl/idot_segment.sv
module idot_segment
  import idot_pkg::*;
(
  input  elem_e             mode,
  input  logic              uns,
  input  logic [1:0]        idx,
  input  logic [SEG_W-1:0]  n_seg,
  input  logic [SEG_W-1:0]  m_seg,
  input  logic [SEG_W-1:0]  acc_seg,
  output logic [SEG_W-1:0]  res_seg
);
  localparam int NB_LANE = SEG_W / BYTE_LW;
  localparam int NH_LANE = SEG_W / HALF_LW;

  logic [4*BYTE_EW-1:0] grp_b;
  logic [4*HALF_EW-1:0] grp_h;
  logic [SEG_W-1:0]     res_b;
  logic [SEG_W-1:0]     res_h;

  // one group per segment, broadcast to all lanes
  assign grp_b = m_seg[idx*BYTE_LW +: BYTE_LW];
  assign grp_h = m_seg[idx[0]*HALF_LW +: HALF_LW];

  for (genvar i = 0; i < NB_LANE; i++) begin : g_blane
    idot_lane #(.EW(BYTE_EW), .LW(BYTE_LW)) u_lane (
      .uns   (uns),
      .n_grp (n_seg[i*BYTE_LW +: BYTE_LW]),
      .m_grp (grp_b),
      .acc   (acc_seg[i*BYTE_LW +: BYTE_LW]),
      .sum   (res_b[i*BYTE_LW +: BYTE_LW])
    );
  end

  for (genvar j = 0; j < NH_LANE; j++) begin : g_hlane
    idot_lane #(.EW(HALF_EW), .LW(HALF_LW)) u_lane (
      .uns   (uns),
      .n_grp (n_seg[j*HALF_LW +: HALF_LW]),
      .m_grp (grp_h),
      .acc   (acc_seg[j*HALF_LW +: HALF_LW]),
      .sum   (res_h[j*HALF_LW +: HALF_LW])
    );
  end

  assign res_seg = (mode == ELEM_HALF) ? res_h : res_b;
endmodule

// File: rtl/idot_unit.sv
module idot_unit
  import idot_pkg::*;
#(
  parameter int VLEN  = 256,
  parameter int LEN_W = $clog2(VLEN/64) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             elem_half,
  input  logic             is_unsigned,
  input  logic [1:0]       idx,
  input  logic [LEN_W-1:0] act_len,
  input  logic [VLEN-1:0]  acc_in,
  input  logic [VLEN-1:0]  src_n,
  input  logic [VLEN-1:0]  src_m,
  output logic             done,
  output logic [VLEN-1:0]  result
);
  localparam int NSEG   = VLEN / SEG_W;
  localparam int NCHUNK = VLEN / CHUNK_W;

  elem_e            mode;
  logic [VLEN-1:0]  seg_out;
  logic [VLEN-1:0]  keep;
  logic [VLEN-1:0]  res_d;
  logic [VLEN-1:0]  res_q;
  logic             done_d;
  logic             done_q;

  assign mode = elem_e'(elem_half);

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    idot_segment u_seg (
      .mode    (mode),
      .uns     (is_unsigned),
      .idx     (idx),
      .n_seg   (src_n [s*SEG_W +: SEG_W]),
      .m_seg   (src_m [s*SEG_W +: SEG_W]),
      .acc_seg (acc_in[s*SEG_W +: SEG_W]),
      .res_seg (seg_out[s*SEG_W +: SEG_W])
    );
  end

  // tail zeroing per 64-bit chunk
  for (genvar c = 0; c < NCHUNK; c++) begin : g_keep
    assign keep[c*CHUNK_W +: CHUNK_W] = {CHUNK_W{act_len > LEN_W'(c)}};
  end

  always_comb begin
    res_d  = res_q;
    done_d = start;
    if (start) begin
      res_d = seg_out & keep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  assign result = res_q;
  assign done   = done_q;
endmodule

// File: rtl/idot_chk.sv
module idot_chk #(
  parameter int VLEN  = 256,
  parameter int LEN_W = $clog2(VLEN/64) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] act_len,
  input logic             done,
  input logic [VLEN-1:0]  result
);
  localparam int NCHUNK = VLEN / 64;

  logic [VLEN-1:0] live_mask;

  always_comb begin
    live_mask = '0;
    for (int c = 0; c < NCHUNK; c++) begin
      if (int'(act_len) > c) live_mask[c*64 +: 64] = '1;
    end
  end

  a_r8_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  a_r8_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));

  a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));

  a_r7_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((result & ~$past(live_mask)) == '0));
endmodule

bind idot_unit idot_chk #(.VLEN(VLEN), .LEN_W(LEN_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .act_len (act_len),
  .done    (done),
  .result  (result)
);

// File: tb/sim_idot_unit.sv
`timescale 1ns/1ps
module sim_idot_unit;
  localparam int VLEN  = 256;
  localparam int LEN_W = $clog2(VLEN/64) + 1;
  localparam int NSEG  = VLEN / 128;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic             elem_half;
  logic             is_unsigned;
  logic [1:0]       idx;
  logic [LEN_W-1:0] act_len;
  logic [VLEN-1:0]  acc_in, src_n, src_m;
  logic             done;
  logic [VLEN-1:0]  result;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  idot_unit #(.VLEN(VLEN), .LEN_W(LEN_W)) u0 (.*);

  function automatic longint ext(input logic [15:0] v, input int w, input logic uns);
    longint r;
    if (w == 8) r = uns ? longint'(v[7:0]) : longint'($signed(v[7:0]));
    else        r = uns ? longint'(v)      : longint'($signed(v));
    return r;
  endfunction

  function automatic logic [VLEN-1:0] model(
    input logic [VLEN-1:0] a, input logic [VLEN-1:0] n, input logic [VLEN-1:0] m,
    input logic half, input logic uns, input logic [1:0] ix, input int len);
    logic [VLEN-1:0] r = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (!half) begin
        for (int i = 0; i < 4; i++) begin
          longint acc = longint'(a[s*128 + i*32 +: 32]);
          for (int k = 0; k < 4; k++)
            acc += ext({8'h0, n[s*128 + i*32 + k*8 +: 8]}, 8, uns) *
                   ext({8'h0, m[s*128 + ix*32 + k*8 +: 8]}, 8, uns);
          r[s*128 + i*32 +: 32] = acc[31:0];
        end
      end else begin
        for (int j = 0; j < 2; j++) begin
          longint acc = longint'(a[s*128 + j*64 +: 64]);
          for (int k = 0; k < 4; k++)
            acc += ext(n[s*128 + j*64 + k*16 +: 16], 16, uns) *
                   ext(m[s*128 + ix[0]*64 + k*16 +: 16], 16, uns);
          r[s*128 + j*64 +: 64] = acc;
        end
      end
    end
    for (int c = 0; c < VLEN/64; c++)
      if (c >= len) r[c*64 +: 64] = '0;
    return r;
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int w = 0; w < VLEN/32; w++) v[w*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic check(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req,
    input logic [VLEN-1:0] a, input logic [VLEN-1:0] n, input logic [VLEN-1:0] m,
    input logic half, input logic uns, input logic [1:0] ix, input int len);
    @(negedge clk);
    acc_in = a; src_n = n; src_m = m; elem_half = half;
    is_unsigned = uns; idx = ix; act_len = LEN_W'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " done"}, VLEN'(done), VLEN'(1));
    check(req, result, model(a, n, m, half, uns, ix, len));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] a, n, m, held, r1;
    void'($urandom(32'h1D07));
    rst_n = 1'b0; start = 1'b0; elem_half = 1'b0; is_unsigned = 1'b0;
    idx = '0; act_len = '0; acc_in = '0; src_n = '0; src_m = '0;
    repeat (3) @(negedge clk);
    check("R9 reset done", VLEN'(done), '0);
    check("R9 reset result", result, '0);
    rst_n = 1'b1;

    // R1 R5 R6: signed extremes and wrap in byte mode
    run_op("R5 signed -128*-128", '0, {VLEN/8{8'h80}}, {VLEN/8{8'h80}}, 1'b0, 1'b0, 2'd0, 4);
    run_op("R5 unsigned 255*255", '0, {VLEN/8{8'hFF}}, {VLEN/8{8'hFF}}, 1'b0, 1'b1, 2'd3, 4);
    run_op("R6 byte wrap", {VLEN/32{32'hFFFF_FFFF}}, {VLEN/8{8'h01}}, {VLEN/8{8'h01}}, 1'b0, 1'b1, 2'd1, 4);
    run_op("R6 half wrap", {VLEN/64{64'hFFFF_FFFF_FFFF_FFFF}}, {VLEN/16{16'h0001}}, {VLEN/16{16'h0002}}, 1'b1, 1'b0, 2'd0, 4);

    // R3: distinct groups per segment
    m = '0;
    for (int s = 0; s < NSEG; s++)
      for (int g = 0; g < 4; g++) m[s*128 + g*32 +: 32] = {4{8'(s*16 + g + 1)}};
    run_op("R3 per-segment group", '0, {VLEN/8{8'h01}}, m, 1'b0, 1'b1, 2'd2, 4);

    // R4: idx[1] ignored in halfword mode
    a = rnd_vec(); n = rnd_vec(); m = rnd_vec();
    run_op("R4 half idx=1", a, n, m, 1'b1, 1'b0, 2'd1, 4);
    r1 = result;
    run_op("R4 half idx=3", a, n, m, 1'b1, 1'b0, 2'd3, 4);
    check("R4 idx bit1 no effect", result, r1);

    // R7: lengths
    run_op("R7 len 1 byte", rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, 1'b0, 2'd3, 1);
    run_op("R7 len 0", rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, 1'b1, 2'd0, 0);
    run_op("R7 len 2 half", rnd_vec(), rnd_vec(), rnd_vec(), 1'b1, 1'b1, 2'd1, 2);
    run_op("R7 len clamp 7", rnd_vec(), rnd_vec(), rnd_vec(), 1'b1, 1'b0, 2'd0, 7);

    // R8: hold without start
    held = result;
    @(negedge clk);
    acc_in = rnd_vec(); src_n = rnd_vec(); src_m = rnd_vec();
    @(negedge clk);
    check("R8 done low", VLEN'(done), '0);
    check("R8 result holds", result, held);

    // random mix for R1 R2 R5
    for (int t = 0; t < 300; t++) begin
      int len = ($urandom() % 3 == 0) ? int'($urandom() % 8) : 4;
      logic half = 1'($urandom());
      run_op(half ? "R2 random" : "R1 random", rnd_vec(), rnd_vec(), rnd_vec(),
             half, 1'($urandom()), 2'($urandom()), len);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule